// File: doc/BRIEF.md
# Two-Sided Mailbox Messaging Unit

This block lets two processors on a shared clock pass 32-bit words and small signals to each other. Each side has its own simple register bus with a select, write strobe, read strobe, byte address and write data, and it gets back combinational read data and one interrupt line. Each side sees four transmit channels, four receive channels, a status word and a control word. A word written into transmit channel n on one side becomes readable in receive channel n on the other side. Per-channel empty and full bits track the hand-off. Reading the word with the read strobe hands the channel back to the sender.

The control word of each side also carries three general flag bits and four general-purpose interrupt requests. The flag bits are mirrored into the other side's status one clock later, and a pending bit covers the update while it is under way. A request shows up as pending in the other side's status until that side acknowledges it. Per-channel enables pick which empty, full and pending conditions raise the side's interrupt.

Top module: `mbx_unit`

## Requirements
- R1: After reset, every register reads 0 on both sides except the status word, which reads 0x00F0_0000 (all four empty bits 20..23 set), and both interrupt outputs are low.
- R2: A write to transmit channel n (byte offset 4n, n = 0..3) stores the word. It reads back at that offset, and the other side reads the same word at receive offset 0x10 + 4n. Writes to the receive offsets change nothing.
- R3: After a transmit write to channel n, the writer's status empty bit 20+n is 0 and the other side's status full bit 24+n is 1 on the next cycle.
- R4: A read-strobed access to receive offset 0x10 + 4n clears the reader's full bit 24+n and sets the sender's empty bit 20+n on the next cycle. If the sender writes channel n in the same cycle, that write wins and the channel stays full.
- R5: Control bits 0..2 written by one side appear in the other side's status bits 0..2 two clock edges after the write. The writer's status bit 8 is 1 for exactly the one cycle after a control write that changes those bits, and 0 otherwise.
- R6: Writing 1 to control bit 16+n raises general request n. Writing 0 there leaves it unchanged. The request reads back in the control word, and the other side sees it as pending in status bit 28+n.
- R7: Writing 1 to status bit 28+n clears pending request n and the requester's control bit 16+n on the next cycle. A clear wins over a set in the same cycle.
- R8: A side's interrupt is high when any of these holds: an empty bit with its enable (control 20..23) set, a full bit with its enable (control 24..27) set, or a pending request with its enable (control 28..31) set.
- R9: Status bits other than 28..31 ignore writes. Offsets 0x28..0x3C read 0. An access whose address bits 1..0 are not 00 reads 0 and has no effect.
- R10: Read data follows the address whenever select is high, and an access without the read strobe changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rstN | input | 1 | Asynchronous active-low reset |
| aSel | input | 1 | Side A select |
| aWr | input | 1 | Side A write strobe |
| aRd | input | 1 | Side A read strobe (enables read side effects) |
| aAddr | input | 6 | Side A byte address |
| aWdata | input | 32 | Side A write data |
| aRdata | output | 32 | Side A read data (combinational) |
| aIrq | output | 1 | Side A interrupt |
| bSel | input | 1 | Side B select |
| bWr | input | 1 | Side B write strobe |
| bRd | input | 1 | Side B read strobe |
| bAddr | input | 6 | Side B byte address |
| bWdata | input | 32 | Side B write data |
| bRdata | output | 32 | Side B read data (combinational) |
| bIrq | output | 1 | Side B interrupt |

## Verification
Read data and the interrupt are combinational from registered state, so the bench compares them against its model in the same cycle the address is applied, 1 ns after the falling edge. It then commits the model update at the rising edge. Transmit, receive, control and acknowledge writes each become visible one edge after the access. The mirrored flag bits need a second edge, and the bench checks this by peeking the status words on both sides in the two cycles that follow a control write. The random phase mixes single-side operations with peeks on the other bus. The directed cases cover the write-over-read collision on a channel, the set-versus-clear collision on a request, and misaligned addresses.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  parameter int DW    = 32;
  parameter int NCH   = 4;
  parameter int NFLAG = 3;
  parameter int AW    = 6;

  localparam int IdxW = AW - 2;
  localparam int ChW  = $clog2(NCH);

  // word indices (byte address / 4)
  localparam logic [IdxW-1:0] IDX_RX_BASE = IdxW'(NCH);
  localparam logic [IdxW-1:0] IDX_STAT    = IdxW'(2 * NCH);
  localparam logic [IdxW-1:0] IDX_CTRL    = IdxW'(2 * NCH + 1);

  // status word field positions
  localparam int PEND_BIT  = 8;
  localparam int EMPTY_LSB = 20;
  localparam int FULL_LSB  = 24;
  localparam int GIP_LSB   = 28;
  // control word field positions
  localparam int GIR_LSB = 16;
  localparam int TIE_LSB = 20;
  localparam int RIE_LSB = 24;
  localparam int GIE_LSB = 28;

  typedef struct packed {
    logic            hit;
    logic [IdxW-1:0] idx;
    logic [NCH-1:0]  txWr;
    logic [NCH-1:0]  rxRd;
    logic [NCH-1:0]  gipClr;
    logic            ctrlWr;
    logic [DW-1:0]   wdata;
  } sideCmd_t;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
(
  input  logic          sel,
  input  logic          wr,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output sideCmd_t      cmd
);
  logic            aligned;
  logic [IdxW-1:0] idx;

  assign aligned = (addr[1:0] == 2'b00);
  assign idx     = addr[AW-1:2];

  always_comb begin
    cmd        = '0;
    cmd.hit    = sel && aligned;
    cmd.idx    = idx;
    cmd.wdata  = wdata;
    cmd.ctrlWr = cmd.hit && wr && (idx == IDX_CTRL);
    for (int n = 0; n < NCH; n++) begin
      cmd.txWr[n]   = cmd.hit && wr && (idx == IdxW'(n));
      cmd.rxRd[n]   = cmd.hit && rd && (idx == IDX_RX_BASE + IdxW'(n));
      cmd.gipClr[n] = cmd.hit && wr && (idx == IDX_STAT) && wdata[GIP_LSB + n];
    end
  end
endmodule

// File: rtl/mbx_side.sv
module mbx_side
  import mbx_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  sideCmd_t                ownCmd,
  input  logic [NCH-1:0]          peerRxRd,
  input  logic [NCH-1:0]          peerGipClr,
  input  logic [NFLAG-1:0]        peerFlags,
  input  logic [NCH-1:0]          peerGir,
  input  logic [NCH-1:0]          peerOcc,
  input  logic [NCH-1:0][DW-1:0]  peerTx,
  output logic [NCH-1:0][DW-1:0]  txOut,
  output logic [NCH-1:0]          occOut,
  output logic [NFLAG-1:0]        flagsOut,
  output logic [NCH-1:0]          girOut,
  output logic [DW-1:0]           rdata,
  output logic [DW-1:0]           status,
  output logic                    irq
);
  logic [NCH-1:0][DW-1:0] txReg;
  logic [NCH-1:0]         occ;      // word from this side not yet taken by peer
  logic [NFLAG-1:0]       flagsR;
  logic [NCH-1:0]         gir, tie, rie, gie;
  logic [NFLAG-1:0]       view;     // peer's flags as seen here
  logic                   pend;
  logic [DW-1:0]          ctrlWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg  <= '0;
      occ    <= '0;
      flagsR <= '0;
      gir    <= '0;
      tie    <= '0;
      rie    <= '0;
      gie    <= '0;
      view   <= '0;
      pend   <= 1'b0;
    end else begin
      for (int n = 0; n < NCH; n++) begin
        if (ownCmd.txWr[n]) txReg[n] <= ownCmd.wdata;
        if (ownCmd.txWr[n]) occ[n] <= 1'b1;
        else if (peerRxRd[n]) occ[n] <= 1'b0;
        if (peerGipClr[n]) gir[n] <= 1'b0;
        else if (ownCmd.ctrlWr && ownCmd.wdata[GIR_LSB + n]) gir[n] <= 1'b1;
      end
      if (ownCmd.ctrlWr) begin
        flagsR <= ownCmd.wdata[NFLAG-1:0];
        tie    <= ownCmd.wdata[TIE_LSB +: NCH];
        rie    <= ownCmd.wdata[RIE_LSB +: NCH];
        gie    <= ownCmd.wdata[GIE_LSB +: NCH];
      end
      pend <= ownCmd.ctrlWr && (ownCmd.wdata[NFLAG-1:0] != flagsR);
      view <= peerFlags;
    end
  end

  always_comb begin
    status                      = '0;
    status[NFLAG-1:0]           = view;
    status[PEND_BIT]            = pend;
    status[EMPTY_LSB +: NCH]    = ~occ;
    status[FULL_LSB +: NCH]     = peerOcc;
    status[GIP_LSB +: NCH]      = peerGir;

    ctrlWord                    = '0;
    ctrlWord[NFLAG-1:0]         = flagsR;
    ctrlWord[GIR_LSB +: NCH]    = gir;
    ctrlWord[TIE_LSB +: NCH]    = tie;
    ctrlWord[RIE_LSB +: NCH]    = rie;
    ctrlWord[GIE_LSB +: NCH]    = gie;
  end

  always_comb begin
    rdata = '0;
    if (ownCmd.hit) begin
      if (ownCmd.idx < IDX_RX_BASE)       rdata = txReg[ownCmd.idx[ChW-1:0]];
      else if (ownCmd.idx < IDX_STAT)     rdata = peerTx[ownCmd.idx[ChW-1:0]];
      else if (ownCmd.idx == IDX_STAT)    rdata = status;
      else if (ownCmd.idx == IDX_CTRL)    rdata = ctrlWord;
    end
  end

  assign irq      = |(~occ & tie) | |(peerOcc & rie) | |(peerGir & gie);
  assign txOut    = txReg;
  assign occOut   = occ;
  assign flagsOut = flagsR;
  assign girOut   = gir;
endmodule

// File: rtl/mbx_unit.sv
module mbx_unit
  import mbx_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          aSel,
  input  logic          aWr,
  input  logic          aRd,
  input  logic [AW-1:0] aAddr,
  input  logic [DW-1:0] aWdata,
  output logic [DW-1:0] aRdata,
  output logic          aIrq,
  input  logic          bSel,
  input  logic          bWr,
  input  logic          bRd,
  input  logic [AW-1:0] bAddr,
  input  logic [DW-1:0] bWdata,
  output logic [DW-1:0] bRdata,
  output logic          bIrq
);
  logic                   busSel  [2];
  logic                   busWr   [2];
  logic                   busRd   [2];
  logic [AW-1:0]          busAddr [2];
  logic [DW-1:0]          busWd   [2];
  sideCmd_t               cmd     [2];
  logic [NCH-1:0][DW-1:0] txV     [2];
  logic [NCH-1:0]         occV    [2];
  logic [NFLAG-1:0]       flagV   [2];
  logic [NCH-1:0]         girV    [2];
  logic [DW-1:0]          rdV     [2];
  logic [DW-1:0]          statV   [2];
  logic                   irqV    [2];
  logic [DW-1:0]          aStatus, bStatus;

  assign busSel[0]  = aSel;   assign busSel[1]  = bSel;
  assign busWr[0]   = aWr;    assign busWr[1]   = bWr;
  assign busRd[0]   = aRd;    assign busRd[1]   = bRd;
  assign busAddr[0] = aAddr;  assign busAddr[1] = bAddr;
  assign busWd[0]   = aWdata; assign busWd[1]   = bWdata;

  for (genvar s = 0; s < 2; s++) begin : g_side
    localparam int P = 1 - s;
    mbx_decode u_dec (
      .sel(busSel[s]), .wr(busWr[s]), .rd(busRd[s]),
      .addr(busAddr[s]), .wdata(busWd[s]), .cmd(cmd[s])
    );
    mbx_side u_side (
      .clk(clk), .rstN(rstN), .ownCmd(cmd[s]),
      .peerRxRd(cmd[P].rxRd), .peerGipClr(cmd[P].gipClr),
      .peerFlags(flagV[P]), .peerGir(girV[P]), .peerOcc(occV[P]),
      .peerTx(txV[P]),
      .txOut(txV[s]), .occOut(occV[s]), .flagsOut(flagV[s]), .girOut(girV[s]),
      .rdata(rdV[s]), .status(statV[s]), .irq(irqV[s])
    );
  end

  assign aRdata  = rdV[0];
  assign bRdata  = rdV[1];
  assign aIrq    = irqV[0];
  assign bIrq    = irqV[1];
  assign aStatus = statV[0];
  assign bStatus = statV[1];
endmodule

// File: rtl/mbx_unit_chk.sv
module mbx_unit_chk
  import mbx_pkg::*;
(
  input logic          clk,
  input logic          rstN,
  input logic          aSel,
  input logic          aWr,
  input logic          aRd,
  input logic [AW-1:0] aAddr,
  input logic [DW-1:0] aWdata,
  input logic          bSel,
  input logic          bWr,
  input logic          bRd,
  input logic [AW-1:0] bAddr,
  input logic [DW-1:0] bWdata,
  input logic [DW-1:0] aStatus,
  input logic [DW-1:0] bStatus
);
  logic [NCH-1:0] aTx, bTx, aRx, bRx, aClr, bClr;
  logic           aCtl;

  always_comb begin
    aTx = '0; bTx = '0; aRx = '0; bRx = '0; aClr = '0; bClr = '0;
    aCtl = aSel && aWr && (aAddr[1:0] == 2'b00) && (aAddr[AW-1:2] == IDX_CTRL);
    for (int n = 0; n < NCH; n++) begin
      aTx[n]  = aSel && aWr && (aAddr == AW'(4 * n));
      bTx[n]  = bSel && bWr && (bAddr == AW'(4 * n));
      aRx[n]  = aSel && aRd && (aAddr == AW'(4 * (NCH + n)));
      bRx[n]  = bSel && bRd && (bAddr == AW'(4 * (NCH + n)));
      aClr[n] = aSel && aWr && (aAddr == AW'(8 * NCH)) && aWdata[GIP_LSB + n];
      bClr[n] = bSel && bWr && (bAddr == AW'(8 * NCH)) && bWdata[GIP_LSB + n];
    end
  end

  a_r3_tx_write_marks: assert property (@(posedge clk) disable iff (!rstN)
    (aTx != 0) |=> ((aStatus[EMPTY_LSB +: NCH] & $past(aTx)) == 0) &&
                   ((bStatus[FULL_LSB +: NCH] & $past(aTx)) == $past(aTx)));

  a_r4_read_releases: assert property (@(posedge clk) disable iff (!rstN)
    ((bRx & ~aTx) != 0) |=> ((bStatus[FULL_LSB +: NCH] & $past(bRx & ~aTx)) == 0) &&
                            ((aStatus[EMPTY_LSB +: NCH] & $past(bRx & ~aTx)) == $past(bRx & ~aTx)));

  a_r5_pend_single: assert property (@(posedge clk) disable iff (!rstN)
    (aStatus[PEND_BIT] && !aCtl) |=> !aStatus[PEND_BIT]);

  a_r5_pend_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(aStatus[PEND_BIT]) |-> $past(aCtl));

  a_r5_mirror_moves: assert property (@(posedge clk) disable iff (!rstN)
    aStatus[PEND_BIT] |=> (bStatus[NFLAG-1:0] != $past(bStatus[NFLAG-1:0])));

  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (bClr != 0) |=> ((bStatus[GIP_LSB +: NCH] & $past(bClr)) == 0));

  a_r7_ack_clears_a: assert property (@(posedge clk) disable iff (!rstN)
    (aClr != 0) |=> ((aStatus[GIP_LSB +: NCH] & $past(aClr)) == 0));

  a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!aSel && !bSel && !aStatus[PEND_BIT] && !bStatus[PEND_BIT]) |=>
      $stable(aStatus[DW-1:EMPTY_LSB]) && $stable(bStatus[DW-1:EMPTY_LSB]));
endmodule

bind mbx_unit mbx_unit_chk i_chk (.*);

// File: tb/test_mbx_unit.sv
module test_mbx_unit;
  localparam int ClkPeriod = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        dSel [2];
  logic        dWr  [2];
  logic        dRd  [2];
  logic [5:0]  dAddr[2];
  logic [31:0] dWd  [2];
  logic [31:0] aRdata, bRdata;
  logic        aIrq, bIrq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // model
  logic [31:0] mTx  [2][4];
  logic [3:0]  mOcc [2];
  logic [2:0]  mFlg [2];
  logic [2:0]  mView[2];
  logic        mPend[2];
  logic [3:0]  mGir [2];
  logic [3:0]  mTie [2];
  logic [3:0]  mRie [2];
  logic [3:0]  mGie [2];

  always #(ClkPeriod / 2) clk = ~clk;

  mbx_unit i_mbx_unit (
    .clk(clk), .rstN(rstN),
    .aSel(dSel[0]), .aWr(dWr[0]), .aRd(dRd[0]), .aAddr(dAddr[0]), .aWdata(dWd[0]),
    .aRdata(aRdata), .aIrq(aIrq),
    .bSel(dSel[1]), .bWr(dWr[1]), .bRd(dRd[1]), .bAddr(dAddr[1]), .bWdata(dWd[1]),
    .bRdata(bRdata), .bIrq(bIrq)
  );

  function automatic logic [31:0] expStatus(int s);
    int p = 1 - s;
    logic [31:0] v = '0;
    v[2:0]   = mView[s];
    v[8]     = mPend[s];
    v[23:20] = ~mOcc[s];
    v[27:24] = mOcc[p];
    v[31:28] = mGir[p];
    return v;
  endfunction

  function automatic logic [31:0] expRead(int s);
    int p = 1 - s;
    int idx = int'(dAddr[s][5:2]);
    if (!dSel[s] || dAddr[s][1:0] != 2'b00) return 32'h0;
    if (idx < 4) return mTx[s][idx];
    if (idx < 8) return mTx[p][idx - 4];
    if (idx == 8) return expStatus(s);
    if (idx == 9) return {mGie[s], mRie[s], mTie[s], mGir[s], 13'h0, mFlg[s]};
    return 32'h0;
  endfunction

  function automatic logic expIrq(int s);
    int p = 1 - s;
    return (|(~mOcc[s] & mTie[s])) | (|(mOcc[p] & mRie[s])) | (|(mGir[p] & mGie[s]));
  endfunction

  task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic resetModel();
    for (int s = 0; s < 2; s++) begin
      for (int n = 0; n < 4; n++) mTx[s][n] = '0;
      mOcc[s] = '0; mFlg[s] = '0; mView[s] = '0; mPend[s] = 1'b0;
      mGir[s] = '0; mTie[s] = '0; mRie[s] = '0; mGie[s] = '0;
    end
  endtask

  task automatic updateModel();
    logic [3:0] txW[2], rxR[2], clr[2];
    logic       cw[2];
    logic [31:0] nTx[2][4];
    logic [3:0] nOcc[2], nGir[2];
    logic [2:0] nView[2];
    logic       nPend[2];
    for (int s = 0; s < 2; s++) begin
      logic ok = dSel[s] && dAddr[s][1:0] == 2'b00;
      int idx = int'(dAddr[s][5:2]);
      cw[s] = ok && dWr[s] && idx == 9;
      for (int n = 0; n < 4; n++) begin
        txW[s][n] = ok && dWr[s] && idx == n;
        rxR[s][n] = ok && dRd[s] && idx == 4 + n;
        clr[s][n] = ok && dWr[s] && idx == 8 && dWd[s][28 + n];
      end
    end
    for (int s = 0; s < 2; s++) begin
      int p = 1 - s;
      for (int n = 0; n < 4; n++) begin
        nTx[s][n] = txW[s][n] ? dWd[s] : mTx[s][n];
        nOcc[s][n] = txW[s][n] ? 1'b1 : (rxR[p][n] ? 1'b0 : mOcc[s][n]);
        nGir[s][n] = clr[p][n] ? 1'b0 : ((cw[s] && dWd[s][16 + n]) ? 1'b1 : mGir[s][n]);
      end
      nView[s] = mFlg[p];
      nPend[s] = cw[s] && (dWd[s][2:0] != mFlg[s]);
    end
    for (int s = 0; s < 2; s++) begin
      for (int n = 0; n < 4; n++) mTx[s][n] = nTx[s][n];
      mOcc[s] = nOcc[s]; mGir[s] = nGir[s]; mView[s] = nView[s]; mPend[s] = nPend[s];
      if (cw[s]) begin
        mFlg[s] = dWd[s][2:0];
        mTie[s] = dWd[s][23:20];
        mRie[s] = dWd[s][27:24];
        mGie[s] = dWd[s][31:28];
      end
    end
  endtask

  task automatic drive(int s, logic sel, logic wr, logic rd, logic [5:0] addr, logic [31:0] wd);
    dSel[s] = sel; dWr[s] = wr; dRd[s] = rd; dAddr[s] = addr; dWd[s] = wd;
  endtask

  task automatic peek(int s, logic [5:0] addr);
    drive(s, 1'b1, 1'b0, 1'b0, addr, 32'h0);
  endtask

  // called just after a falling edge with inputs driven
  task automatic tick(string tag);
    #1;
    check(tag, "side A read", aRdata, expRead(0));
    check(tag, "side B read", bRdata, expRead(1));
    check(tag, "side A irq", {31'h0, aIrq}, {31'h0, expIrq(0)});
    check(tag, "side B irq", {31'h0, bIrq}, {31'h0, expIrq(1)});
    @(posedge clk);
    updateModel();
    @(negedge clk);
    drive(0, 1'b0, 1'b0, 1'b0, 6'h0, 32'h0);
    drive(1, 1'b0, 1'b0, 1'b0, 6'h0, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL timeout: got hung run expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seedV;
    seedV = $urandom(32'h1F2E3D4C);
    drive(0, 1'b0, 1'b0, 1'b0, 6'h0, 32'h0);
    drive(1, 1'b0, 1'b0, 1'b0, 6'h0, 32'h0);
    resetModel();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state on every offset
    for (int k = 0; k < 16; k++) begin
      peek(0, 6'(4 * k)); peek(1, 6'(4 * k));
      tick("R1");
    end
    peek(0, 6'h20); peek(1, 6'h20);
    #1;
    check("R1", "status A reset", aRdata, 32'h00F0_0000);
    check("R1", "status B reset", bRdata, 32'h00F0_0000);
    @(negedge clk);

    // R2/R3: A writes channel 1, B sees word and full, A sees not-empty
    drive(0, 1'b1, 1'b1, 1'b0, 6'h04, 32'hCAFE_0001); peek(1, 6'h14); tick("R2");
    peek(0, 6'h04); peek(1, 6'h14); tick("R2");
    peek(0, 6'h20); peek(1, 6'h20);
    #1;
    check("R3", "A empty bit 21", {31'h0, aRdata[21]}, 32'h0);
    check("R3", "B full bit 25", {31'h0, bRdata[25]}, 32'h1);
    @(negedge clk);
    // R2: write to a receive offset is ignored
    drive(1, 1'b1, 1'b1, 1'b0, 6'h14, 32'h1234_5678); peek(0, 6'h04); tick("R2");
    peek(1, 6'h14); tick("R2");

    // R4: B reads channel 1 with strobe
    drive(1, 1'b1, 1'b0, 1'b1, 6'h14, 32'h0); peek(0, 6'h20); tick("R4");
    peek(0, 6'h20); peek(1, 6'h20); tick("R4");
    // R4: collision, A writes ch2 twice, B reads ch2 while A writes again
    drive(0, 1'b1, 1'b1, 1'b0, 6'h08, 32'h0000_00A2); tick("R4");
    drive(0, 1'b1, 1'b1, 1'b0, 6'h08, 32'h0000_00B2);
    drive(1, 1'b1, 1'b0, 1'b1, 6'h18, 32'h0); tick("R4");
    peek(0, 6'h20); peek(1, 6'h20);
    #1;
    check("R4", "B full bit 26 after collision", {31'h0, bRdata[26]}, 32'h1);
    check("R4", "A empty bit 22 after collision", {31'h0, aRdata[22]}, 32'h0);
    @(negedge clk);
    peek(1, 6'h18); tick("R4");

    // R5: flag mirror timing
    drive(0, 1'b1, 1'b1, 1'b0, 6'h24, 32'h0000_0005); peek(1, 6'h20); tick("R5");
    peek(0, 6'h20); peek(1, 6'h20); tick("R5");
    peek(0, 6'h20); peek(1, 6'h20); tick("R5");
    // R5: same flags again, no pending
    drive(0, 1'b1, 1'b1, 1'b0, 6'h24, 32'h0000_0005); tick("R5");
    peek(0, 6'h20); tick("R5");

    // R6: raise request 2 from A, write 0 has no effect
    drive(0, 1'b1, 1'b1, 1'b0, 6'h24, 32'h0004_0005); tick("R6");
    drive(0, 1'b1, 1'b1, 1'b0, 6'h24, 32'h0000_0005); peek(1, 6'h20); tick("R6");
    peek(0, 6'h24); peek(1, 6'h20); tick("R6");
    // R8: B enables general irq 2
    drive(1, 1'b1, 1'b1, 1'b0, 6'h24, 32'h4000_0000); tick("R8");
    peek(1, 6'h20); tick("R8");
    // R7: B acknowledges while A sets again in the same cycle
    drive(1, 1'b1, 1'b1, 1'b0, 6'h20, 32'h4000_0000);
    drive(0, 1'b1, 1'b1, 1'b0, 6'h24, 32'h0004_0005); tick("R7");
    peek(0, 6'h24); peek(1, 6'h20); tick("R7");

    // R8: transmit-empty and receive-full enables
    drive(1, 1'b1, 1'b1, 1'b0, 6'h24, 32'h0010_0000); tick("R8");
    peek(1, 6'h24); tick("R8");
    drive(1, 1'b1, 1'b1, 1'b0, 6'h24, 32'h0400_0000); tick("R8");
    drive(1, 1'b1, 1'b0, 1'b1, 6'h18, 32'h0); tick("R8");
    peek(1, 6'h20); tick("R8");

    // R9: writes to read-only status bits, unmapped and misaligned offsets
    drive(0, 1'b1, 1'b1, 1'b0, 6'h20, 32'h0FFF_01FF); tick("R9");
    peek(0, 6'h20); peek(1, 6'h2C); tick("R9");
    drive(0, 1'b1, 1'b1, 1'b0, 6'h01, 32'hDEAD_BEEF); peek(1, 6'h3C); tick("R9");
    peek(0, 6'h00); peek(1, 6'h11); tick("R9");
    drive(1, 1'b1, 1'b0, 1'b1, 6'h15, 32'h0); tick("R9");

    // R10: random mix
    for (int k = 0; k < 600; k++) begin
      int s = int'($urandom % 2);
      int p = 1 - s;
      int kind = int'($urandom % 6);
      logic [5:0] ch = 6'($urandom % 4);
      logic [31:0] rnd = $urandom;
      string tag;
      case (kind)
        0: begin drive(s, 1'b1, 1'b1, 1'b0, ch << 2, rnd); tag = "R2"; end
        1: begin drive(s, 1'b1, 1'b0, 1'b1, 6'h10 + (ch << 2), 32'h0); tag = "R4"; end
        2: begin drive(s, 1'b1, 1'b1, 1'b0, 6'h24, rnd & 32'hFFF1_0007); tag = "R5"; end
        3: begin drive(s, 1'b1, 1'b1, 1'b0, 6'h20, rnd); tag = "R7"; end
        4: begin peek(s, 6'($urandom % 64)); tag = "R10"; end
        default: begin drive(s, 1'b1, 1'b1, 1'b0, 6'h10 + (ch << 2), rnd); tag = "R9"; end
      endcase
      peek(p, 6'(($urandom % 2 == 0) ? 6'h20 : 6'($urandom % 64)));
      tick(tag);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule